// File: doc/BRIEF.md
# Indexed Block Register Slave for a Two-Wire Bus

This block is a two-wire serial-bus target that owns a small bank of 8-bit configuration registers. The registers drive the rest of the chip in parallel. A host on the bus can reach them only through block transfers that name a starting index. The block oversamples the bus clock and data lines on a fast system clock. It finds START, repeated START and STOP conditions on its own, and it pulls the data line low through an open-drain enable.

A write names the device, then a starting index, then a byte count, and then streams data bytes. Each data byte goes to the next register in ascending order until the host sends STOP. A read first sets the index with a short write. The host then sends a repeated START and the read address. The block answers with a byte that gives the number of registers, followed by register contents from the index upward, until the host refuses a byte.

Top module: `smb_idx_slave`

## Requirements
- R1: After reset every register holds its default value (register i resets to 0x10+i with the default parameters) and the open-drain enable is inactive.
- R2: Only the address bytes 0xD4 (write) and 0xD5 (read) are acknowledged. After any other address byte the slave never pulls the data line low until the next START.
- R3: In a write, the address, the index byte, the count byte and every data byte are acknowledged. The first data byte is stored at the given index, and each later byte is stored at the next higher index.
- R4: The count byte does not limit a write. Data bytes keep loading into successive registers until STOP, even past the count.
- R5: A data byte aimed at an index of 8 or above (the register count) is acknowledged and then discarded, and no register changes.
- R6: After a repeated START with address 0xD5, the first byte the slave sends is the register count, 8 by default.
- R7: After the count byte, the slave sends registers in ascending order starting at the index set by the preceding write. Indexes of 8 and above read as 0x00.
- R8: When the host answers a sent byte with NACK, the slave releases the data line and drives nothing more until the next START.
- R9: A STOP at any point returns the slave to idle with the line released. Bytes completed before the STOP stay written, and a partial byte is dropped.
- R10: The slave changes its data-line drive only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least ten times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls the data line low |
| cfg_regs | output | NREG*8 | All registers, register i in bits [8i+7:8i] |

## Verification
The assertions assume that the host changes the data line only while the bus clock is low, except when it forms START and STOP. They also assume that each level of either line lasts for several system clocks, so that the synchronised copies never see a data edge and a clock edge at the same time. The bench models the host with tasks that hold every level for ten system clocks. The host moves the data line a quarter bit after the clock falls and samples it in the middle of the high phase. The slave's release after each acknowledge therefore happens well before the next clock rise.

// File: rtl/smb_idx_pkg.sv
package smb_idx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXEND,
    ST_ACKOUT,
    ST_TX,
    ST_ACKIN
  } xfer_st_e;

  typedef enum logic [1:0] {
    ROLE_ADDR,
    ROLE_INDEX,
    ROLE_COUNT,
    ROLE_DATA
  } rx_role_e;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [SYNC_STAGES-1:0] scl_pipe_q, scl_pipe_d;
  logic [SYNC_STAGES-1:0] sda_pipe_q, sda_pipe_d;
  logic scl_prev_q, sda_prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      assign scl_pipe_d = scl_i;
      assign sda_pipe_d = sda_i;
    end else begin : g_chain
      assign scl_pipe_d = {scl_pipe_q[SYNC_STAGES-2:0], scl_i};
      assign sda_pipe_d = {sda_pipe_q[SYNC_STAGES-2:0], sda_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_pipe_q <= scl_pipe_d;
      sda_pipe_q <= sda_pipe_d;
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  assign scl_s     = scl_pipe_q[SYNC_STAGES-1];
  assign sda_s     = sda_pipe_q[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev_q;
  assign scl_fall  = ~scl_s & scl_prev_q;
  assign start_evt = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_evt  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
  parameter int              NREG = 8,
  parameter logic [NREG*8-1:0] INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        rd_idx,
  output logic [7:0]        rd_data,
  output logic [NREG*8-1:0] regs_flat
);

  localparam logic [7:0] LAST_IDX = 8'(NREG - 1);

  genvar gi;
  generate
    for (gi = 0; gi < NREG; gi++) begin : g_reg
      logic       hit;
      logic [7:0] val_q;
      assign hit = wr_en && (wr_idx == 8'(gi));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          val_q <= INIT[gi*8 +: 8];
        end else if (hit) begin
          val_q <= wr_data;
        end
      end
      assign regs_flat[gi*8 +: 8] = val_q;
    end
  endgenerate

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NREG; i++) begin
      if (rd_idx == 8'(i)) rd_data = regs_flat[i*8 +: 8];
    end
  end

  assert_oob_discard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx > LAST_IDX)) |=> $stable(regs_flat));

endmodule

// File: rtl/smb_idx_slave.sv
module smb_idx_slave
  import smb_idx_pkg::*;
#(
  parameter int                NREG        = 8,
  parameter logic [6:0]        DEV_ADDR    = 7'h6A,
  parameter int                SYNC_STAGES = 2,
  parameter logic [NREG*8-1:0] INIT        = 64'h17161514_13121110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] cfg_regs
);

  localparam logic [7:0] ADDR_WR  = {DEV_ADDR, 1'b0};
  localparam logic [7:0] ADDR_RD  = {DEV_ADDR, 1'b1};
  localparam logic [7:0] CNT_BYTE = 8'(NREG);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  xfer_st_e   st_q, st_d;
  rx_role_e   role_q, role_d;
  logic [2:0] bitcnt_q, bitcnt_d;
  logic [7:0] shreg_q, shreg_d;
  logic [7:0] ptr_q, ptr_d;
  logic       read_q, read_d;
  logic       hack_q, hack_d;
  logic       oe_q, oe_d;
  logic       wr_en_c;
  logic       ack_c;
  logic [7:0] rd_data;
  logic [7:0] ptr_inc;

  smb_reg_bank #(.NREG(NREG), .INIT(INIT)) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .wr_en     (wr_en_c),
    .wr_idx    (ptr_q),
    .wr_data   (shreg_q),
    .rd_idx    (ptr_q),
    .rd_data   (rd_data),
    .regs_flat (cfg_regs)
  );

  assign ptr_inc = (ptr_q == 8'hFF) ? ptr_q : ptr_q + 8'd1;

  always_comb begin
    st_d     = st_q;
    role_d   = role_q;
    bitcnt_d = bitcnt_q;
    shreg_d  = shreg_q;
    ptr_d    = ptr_q;
    read_d   = read_q;
    hack_d   = hack_q;
    oe_d     = oe_q;
    wr_en_c  = 1'b0;
    ack_c    = 1'b0;
    if (start_evt) begin
      st_d     = ST_RX;
      role_d   = ROLE_ADDR;
      bitcnt_d = 3'd0;
      read_d   = 1'b0;
      oe_d     = 1'b0;
    end else if (stop_evt) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else begin
      case (st_q)
        ST_RX: begin
          if (scl_rise) begin
            shreg_d = {shreg_q[6:0], sda_s};
            if (bitcnt_q == 3'd7) st_d = ST_RXEND;
            else                  bitcnt_d = bitcnt_q + 3'd1;
          end
        end
        ST_RXEND: begin
          if (scl_fall) begin
            bitcnt_d = 3'd0;
            ack_c    = 1'b1;
            case (role_q)
              ROLE_ADDR: begin
                if (shreg_q == ADDR_WR) begin
                  role_d = ROLE_INDEX;
                  read_d = 1'b0;
                end else if (shreg_q == ADDR_RD) begin
                  read_d = 1'b1;
                end else begin
                  ack_c = 1'b0;
                end
              end
              ROLE_INDEX: begin
                ptr_d  = shreg_q;
                role_d = ROLE_COUNT;
              end
              ROLE_COUNT: role_d = ROLE_DATA;
              default: begin
                wr_en_c = 1'b1;
                ptr_d   = ptr_inc;
              end
            endcase
            st_d = ack_c ? ST_ACKOUT : ST_IDLE;
            oe_d = ack_c;
          end
        end
        ST_ACKOUT: begin
          if (scl_fall) begin
            bitcnt_d = 3'd0;
            if (read_q) begin
              st_d    = ST_TX;
              shreg_d = CNT_BYTE;
              oe_d    = ~CNT_BYTE[7];
            end else begin
              st_d = ST_RX;
              oe_d = 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt_q == 3'd7) begin
              st_d = ST_ACKIN;
              oe_d = 1'b0;
            end else begin
              shreg_d  = {shreg_q[6:0], 1'b0};
              bitcnt_d = bitcnt_q + 3'd1;
              oe_d     = ~shreg_q[6];
            end
          end
        end
        ST_ACKIN: begin
          if (scl_rise) hack_d = ~sda_s;
          if (scl_fall) begin
            if (hack_q) begin
              st_d     = ST_TX;
              bitcnt_d = 3'd0;
              shreg_d  = rd_data;
              oe_d     = ~rd_data[7];
              ptr_d    = ptr_inc;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      st_q     <= ST_IDLE;
      role_q   <= ROLE_ADDR;
      bitcnt_q <= 3'd0;
      shreg_q  <= 8'h00;
      ptr_q    <= 8'h00;
      read_q   <= 1'b0;
      hack_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      st_q     <= st_d;
      role_q   <= role_d;
      bitcnt_q <= bitcnt_d;
      shreg_q  <= shreg_d;
      ptr_q    <= ptr_d;
      read_q   <= read_d;
      hack_q   <= hack_d;
      oe_q     <= oe_d;
    end
  end

  assign sda_oe = oe_q;

  assert_foreign_addr_nack_R2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (st_q == ST_RXEND && role_q == ROLE_ADDR && scl_fall &&
     shreg_q != ADDR_WR && shreg_q != ADDR_RD) |=> (st_q == ST_IDLE && !oe_q));

  assert_idle_released_R8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (st_q == ST_IDLE) |-> !oe_q);

  assert_stop_releases_R9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    stop_evt |=> (!oe_q && st_q == ST_IDLE));

  assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (oe_q != $past(oe_q)) |-> !scl_s);

  assert_tx_count_first_R6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (st_q == ST_ACKOUT && read_q && scl_fall) |=> (st_q == ST_TX && shreg_q == CNT_BYTE));

endmodule

// File: tb/smb_idx_slave_bench.sv
module smb_idx_slave_bench;

  localparam int NREG = 8;
  localparam int Q    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] cfg_regs;
  wire  sda_line = sda_m & ~sda_oe;

  int n_checks = 0;
  int n_fail   = 0;
  int r10_viol = 0;
  bit done     = 1'b0;
  logic prev_oe = 1'b0;
  logic [7:0] mdl [NREG];

  always #4 clk = ~clk;

  smb_idx_slave u_smb_idx_slave (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .sda_oe   (sda_oe),
    .cfg_regs (cfg_regs)
  );

  // R10 monitor: drive changes seen while the bus clock is high
  always @(negedge clk) begin
    if (sda_oe !== prev_oe && scl_m) r10_viol++;
    prev_oe <= sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_xfer(input logic b, output logic r);
    sda_m = b;  wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    r = sda_line; wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic bus_start();
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b1; wait_q(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], r);
    bit_xfer(1'b1, r);
    acked = ~r;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, r);
      b[i] = r;
    end
    bit_xfer(~ack, r);
  endtask

  task automatic cmp_regs(input string req);
    for (int i = 0; i < NREG; i++) chk(req, 32'(cfg_regs[i*8 +: 8]), 32'(mdl[i]));
  endtask

  task automatic t_reset();
    chk("R1 sda_oe", 32'(sda_oe), 32'd0);
    cmp_regs("R1 defaults");
  endtask

  task automatic t_write_basic();
    logic a;
    bus_start();
    send_byte(8'hD4, a); chk("R3 addr ack", 32'(a), 32'd1);
    send_byte(8'h02, a); chk("R3 index ack", 32'(a), 32'd1);
    send_byte(8'h03, a); chk("R3 count ack", 32'(a), 32'd1);
    send_byte(8'hAA, a); chk("R3 data ack", 32'(a), 32'd1);
    send_byte(8'hBB, a); chk("R3 data ack", 32'(a), 32'd1);
    send_byte(8'hCC, a); chk("R3 data ack", 32'(a), 32'd1);
    bus_stop();
    mdl[2] = 8'hAA; mdl[3] = 8'hBB; mdl[4] = 8'hCC;
    cmp_regs("R3 ascending store");
  endtask

  task automatic t_read(input logic [7:0] idx, input int nbytes);
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD4, a); chk("R6 addr ack", 32'(a), 32'd1);
    send_byte(idx, a);   chk("R6 index ack", 32'(a), 32'd1);
    bus_rstart();
    send_byte(8'hD5, a); chk("R6 read addr ack", 32'(a), 32'd1);
    recv_byte(1'b1, b);  chk("R6 count byte", 32'(b), 32'(NREG));
    for (int k = 0; k < nbytes; k++) begin
      int j = int'(idx) + k;
      recv_byte(k != nbytes - 1, b);
      chk("R7 read data", 32'(b), (j < NREG) ? 32'(mdl[j]) : 32'd0);
    end
    // after NACK the slave must leave the line alone
    for (int k = 0; k < 3; k++) begin
      logic r;
      bit_xfer(1'b1, r);
      chk("R8 released after NACK", 32'(r), 32'd1);
    end
    bus_stop();
  endtask

  task automatic t_write_overrun();
    logic a;
    bus_start();
    send_byte(8'hD4, a);
    send_byte(8'h06, a);
    send_byte(8'h01, a); chk("R4 count ack", 32'(a), 32'd1);
    send_byte(8'h5A, a);
    send_byte(8'hA5, a); chk("R4 byte past count ack", 32'(a), 32'd1);
    send_byte(8'h11, a); chk("R5 out-of-range ack", 32'(a), 32'd1);
    send_byte(8'h22, a); chk("R5 out-of-range ack", 32'(a), 32'd1);
    bus_stop();
    mdl[6] = 8'h5A; mdl[7] = 8'hA5;
    cmp_regs("R4 R5 overrun result");
  endtask

  task automatic t_foreign();
    logic a;
    bus_start();
    send_byte(8'hA0, a); chk("R2 foreign addr nack", 32'(a), 32'd0);
    send_byte(8'h00, a); chk("R2 no drive after foreign", 32'(a), 32'd0);
    send_byte(8'h99, a); chk("R2 no drive after foreign", 32'(a), 32'd0);
    bus_stop();
    cmp_regs("R2 regs untouched");
  endtask

  task automatic t_stop_mid();
    logic a;
    logic r;
    bus_start();
    send_byte(8'hD4, a);
    send_byte(8'h00, a);
    bus_stop();
    cmp_regs("R9 stop after index");
    bus_start();
    send_byte(8'hD4, a);
    send_byte(8'h00, a);
    send_byte(8'h02, a);
    send_byte(8'h55, a);
    for (int i = 0; i < 4; i++) bit_xfer(1'b0, r);
    bus_stop();
    chk("R9 line released after stop", 32'(sda_oe), 32'd0);
    mdl[0] = 8'h55;
    cmp_regs("R9 partial byte dropped");
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) mdl[i] = 8'h10 + 8'(i);
    wait_q(5);
    rst_n = 1'b1;
    wait_q(10);
    t_reset();
    t_write_basic();
    t_read(8'h01, 4);
    t_write_overrun();
    t_read(8'h07, 2);
    t_foreign();
    t_stop_mid();
    chk("R10 drive changes with clock high", 32'(r10_viol), 32'd0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule